// File: doc/BRIEF.md
# Two-Class Priority Address Queue

This block is the departure-side controller for one output port of a shared-memory cell switch. Every cell bound for the port is stored somewhere in a common cell RAM. The block keeps the RAM addresses of the waiting cells in two queues, one for the urgent class and one for the bulk class. On each departure slot it hands out the next address to read.

Selection uses strict priority. An urgent address always leaves before any bulk address. Within a class, addresses leave in the order they arrived. The address that is read is returned on a release strobe in the same cycle, so the free-address pool can reuse that location.

Each queue can hold every location of the cell RAM. A push into a queue that is already full is dropped and noted in a sticky flag.

Top module: `prio_addr_queue`

## Requirements
- R1: While reset is asserted and right after reset, `rd_valid_o`, `rel_valid_o` and `ovf_o` are 0.
- R2: A push with `push_cls_i`=1 enters the urgent queue and a push with `push_cls_i`=0 enters the bulk queue. A read reports its source on `rd_hi_o` (1 = urgent, 0 = bulk).
- R3: On a slot strobe, if the urgent queue holds any address, the read comes from the urgent queue.
- R4: On a slot strobe, the bulk queue is read only when the urgent queue is empty and the bulk queue is not empty.
- R5: A slot strobe while both queues are empty produces no read and no release, and pops neither queue.
- R6: Within one class, addresses are read out in the order they were pushed.
- R7: `rd_valid_o`, `rd_addr_o` and `rd_hi_o` are registered. They are valid in the cycle after the clock edge that samples `slot_i`, and `rd_valid_o` is a one-cycle pulse for each read.
- R8: `rel_valid_o` and `rel_addr_o` equal `rd_valid_o` and `rd_addr_o` in every cycle.
- R9: A read from one queue leaves the other queue's contents and order unchanged.
- R10: A push and a pop of the same queue in the same cycle are both carried out, including when that queue is full.
- R11: Each queue holds 2**ADDR_W addresses. A push into a full queue with no pop of that queue in the same cycle is dropped and sets `ovf_o`. `ovf_o` stays 1 until reset.
- R12: A push sampled on the same edge as a slot strobe is not eligible for that slot. It can be read from the next slot onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Store the address of a newly written cell |
| push_addr_i | input | ADDR_W | Cell RAM address to enqueue |
| push_cls_i | input | 1 | Class of the pushed cell (1 urgent, 0 bulk) |
| slot_i | input | 1 | Departure slot: pick and pop one address |
| rd_valid_o | output | 1 | A read is issued this cycle |
| rd_addr_o | output | ADDR_W | Cell RAM address to read |
| rd_hi_o | output | 1 | The read came from the urgent queue |
| rel_valid_o | output | 1 | Release strobe to the free-address pool |
| rel_addr_o | output | ADDR_W | Address being released |
| ovf_o | output | 1 | Sticky flag: a push was dropped |

## Verification
The assertions check the following on every cycle:
- A queue is never popped while it is empty.
- Only one queue is popped at a time, and the bulk queue only while the urgent queue is empty.
- A slot with urgent work always yields an urgent read.
- A slot with nothing queued yields no read.
- A queue's level holds steady under a simultaneous push and pop.
- The overflow flag never clears on its own.

FIFO order within a class, and the contents of the other queue surviving a read, can only be shown by the bench's scenarios. The same holds for exact address values, for a same-cycle push not being eligible, and for the full-queue drop. The bench's scenarios cover mixed-class fills, interleaved pushes during draining, a full queue plus one extra push, and a reset that clears the flag.

// File: rtl/prio_q_pkg.sv
package prio_q_pkg;
  localparam int NUM_CLS = 2;
  typedef enum logic {
    CLS_LO = 1'b0,
    CLS_HI = 1'b1
  } cls_e;
endpackage

// File: rtl/prio_addr_fifo.sv
module prio_addr_fifo #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              drop_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              accept;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign accept  = push_i && (!full_o || pop_i);
  assign drop_o  = push_i && full_o && !pop_i;
  assign head_o  = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (accept) wptr_d = wptr_q + 1'b1;
    if (pop_i)  rptr_d = rptr_q + 1'b1;
    case ({accept, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr_q] <= data_i;
  end

  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import prio_q_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_i,
  input  logic [NUM_CLS-1:0] empty_i,
  output logic [NUM_CLS-1:0] pop_o,
  output logic               grant_o,
  output logic               grant_hi_o
);
  always_comb begin
    pop_o      = '0;
    grant_o    = 1'b0;
    grant_hi_o = 1'b0;
    if (slot_i) begin
      if (!empty_i[CLS_HI]) begin
        pop_o[CLS_HI] = 1'b1;
        grant_o       = 1'b1;
        grant_hi_o    = 1'b1;
      end else if (!empty_i[CLS_LO]) begin
        pop_o[CLS_LO] = 1'b1;
        grant_o       = 1'b1;
      end
    end
  end

  // R3
  one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_o));

  // R4
  lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o[CLS_LO] |-> empty_i[CLS_HI]);
endmodule

// File: rtl/prio_addr_queue.sv
module prio_addr_queue
  import prio_q_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              push_cls_i,
  input  logic              slot_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_hi_o,
  output logic              rel_valid_o,
  output logic [ADDR_W-1:0] rel_addr_o,
  output logic              ovf_o
);
  logic [NUM_CLS-1:0] pop, empty, full, drop;
  logic [ADDR_W-1:0]  head [NUM_CLS];
  logic               grant, grant_hi;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    prio_addr_fifo #(.ADDR_W(ADDR_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_i && (push_cls_i == 1'(c))),
      .data_i  (push_addr_i),
      .pop_i   (pop[c]),
      .head_o  (head[c]),
      .empty_o (empty[c]),
      .full_o  (full[c]),
      .drop_o  (drop[c])
    );
  end

  prio_pick u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_i     (slot_i),
    .empty_i    (empty),
    .pop_o      (pop),
    .grant_o    (grant),
    .grant_hi_o (grant_hi)
  );

  logic              rd_valid_q, rd_valid_d;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic              rd_hi_q, rd_hi_d;
  logic              ovf_q, ovf_d;
  logic              addr_en;

  always_comb begin
    rd_valid_d = grant;
    addr_en    = grant;
    rd_addr_d  = grant_hi ? head[CLS_HI] : head[CLS_LO];
    rd_hi_d    = grant_hi;
    ovf_d      = ovf_q || (|drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
      rd_hi_q    <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
      ovf_q      <= ovf_d;
      if (addr_en) begin
        rd_addr_q <= rd_addr_d;
        rd_hi_q   <= rd_hi_d;
      end
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_addr_o   = rd_addr_q;
  assign rd_hi_o     = rd_hi_q;
  assign rel_valid_o = rd_valid_q;
  assign rel_addr_o  = rd_addr_q;
  assign ovf_o       = ovf_q;

  // R3
  hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && !empty[CLS_HI]) |=> (rd_valid_o && rd_hi_o));

  // R5
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && (&empty)) |=> !rd_valid_o);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
endmodule

// File: tb/prio_addr_queue_bench.sv
`timescale 1ns/1ps
module prio_addr_queue_bench;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_i, push_cls_i, slot_i;
  logic [AW-1:0] push_addr_i;
  logic          rd_valid_o, rd_hi_o, rel_valid_o, ovf_o;
  logic [AW-1:0] rd_addr_o, rel_addr_o;

  always #2.5 clk = ~clk;

  prio_addr_queue #(.ADDR_W(AW)) u_prio_addr_queue (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .push_cls_i(push_cls_i), .slot_i(slot_i), .rd_valid_o(rd_valid_o),
    .rd_addr_o(rd_addr_o), .rd_hi_o(rd_hi_o), .rel_valid_o(rel_valid_o),
    .rel_addr_o(rel_addr_o), .ovf_o(ovf_o)
  );

  typedef struct {
    bit    v;
    int    a;
    bit    hi;
    bit    ovf;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   hi_m[$];
  int   lo_m[$];
  bit   ovf_m;
  int   n_chk = 0;
  int   n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input bit p, input int a, input bit c, input bit s,
                      input string tag);
    exp_t e;
    bit   popped_hi, popped_lo;
    @(negedge clk);
    push_i = p; push_addr_i = AW'(a); push_cls_i = c; slot_i = s;
    e.v = 0; e.a = 0; e.hi = 0; e.tag = tag;
    popped_hi = 0; popped_lo = 0;
    if (s) begin
      if (hi_m.size() > 0) begin
        e.v = 1; e.hi = 1; e.a = hi_m.pop_front(); popped_hi = 1;
      end else if (lo_m.size() > 0) begin
        e.v = 1; e.hi = 0; e.a = lo_m.pop_front(); popped_lo = 1;
      end
    end
    if (p) begin
      if (c) begin
        if (hi_m.size() < DEPTH || popped_hi) hi_m.push_back(a);
        else ovf_m = 1;
      end else begin
        if (lo_m.size() < DEPTH || popped_lo) lo_m.push_back(a);
        else ovf_m = 1;
      end
    end
    e.ovf = ovf_m;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, "R5");
  endtask

  // Monitor: compares the design's registered outputs one cycle later.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rd_valid_o == e.v, (e.v ? "R7" : "R5"), "rd_valid", int'(rd_valid_o), int'(e.v));
        if (e.v) begin
          chk(int'(rd_addr_o) == e.a, e.tag, "rd_addr", int'(rd_addr_o), e.a);
          chk(rd_hi_o == e.hi, "R2", "rd_hi", int'(rd_hi_o), int'(e.hi));
        end
        chk(rel_valid_o == rd_valid_o, "R8", "rel_valid", int'(rel_valid_o), int'(rd_valid_o));
        if (rel_valid_o)
          chk(rel_addr_o == rd_addr_o, "R8", "rel_addr", int'(rel_addr_o), int'(rd_addr_o));
        chk(ovf_o == e.ovf, "R11", "ovf", int'(ovf_o), int'(e.ovf));
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    push_i = 0; push_addr_i = '0; push_cls_i = 0; slot_i = 0; ovf_m = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!rd_valid_o && !rel_valid_o && !ovf_o, "R1", "outputs in reset",
        int'({rd_valid_o, rel_valid_o, ovf_o}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_valid_o && !rel_valid_o && !ovf_o, "R1", "outputs after reset",
        int'({rd_valid_o, rel_valid_o, ovf_o}), 0);

    // R5: slot with both queues empty
    step(0, 0, 0, 1, "R5");
    step(0, 0, 0, 1, "R5");

    // R2 R3 R4 R6: bulk pushed first, urgent must still leave first
    step(1, 10, 0, 0, "R2");
    step(1, 11, 0, 0, "R2");
    step(1, 12, 0, 0, "R2");
    step(1, 40, 1, 0, "R2");
    step(1, 41, 1, 0, "R2");
    step(0, 0, 0, 1, "R3");
    step(0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, "R4");
    // R9: an urgent arrival between bulk reads leaves bulk order intact
    step(1, 50, 1, 0, "R9");
    step(0, 0, 0, 1, "R3");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, "R5");

    // R12: a push on the slot edge is not read by that slot
    step(1, 33, 0, 1, "R12");
    step(0, 0, 0, 1, "R12");
    // R10: push and pop of the same queue together
    step(1, 20, 1, 0, "R10");
    step(1, 21, 1, 1, "R10");
    step(1, 22, 1, 1, "R10");
    step(0, 0, 0, 1, "R10");
    step(0, 0, 0, 1, "R5");

    // R11: fill the urgent queue, then push once more with no pop
    for (int i = 0; i < DEPTH; i++) step(1, i, 1, 0, "R11");
    step(1, 7, 1, 0, "R11");
    // R10: a full queue accepts a push when it is popped in the same cycle
    step(1, 63, 1, 1, "R10");
    step(1, 5, 0, 0, "R9");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, "R4");
    step(0, 0, 0, 1, "R5");
    idle(2);
    @(negedge clk);
    @(negedge clk);

    // R11: only reset clears the flag
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    ovf_m = 0;
    hi_m.delete();
    lo_m.delete();
    @(negedge clk);
    chk(ovf_o == 0, "R11", "ovf after reset", int'(ovf_o), 0);
    chk(rd_valid_o == 0, "R1", "rd_valid after reset", int'(rd_valid_o), 0);
    step(0, 0, 0, 1, "R5");
    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule